// File: doc/BRIEF.md
# Serial-Loaded Control Register Port

This block sits on a CPU write bus and builds four small control registers out of single-bit writes. Every accepted write to the upper half of the address space carries one payload bit in data bit 0. The block collects these bits least-significant first in a hidden shift buffer. On the fifth payload bit, the assembled 5-bit word is stored in one of four registers. The register is chosen by address bits 14:13 of that fifth write alone.

Data bit 7 works as an in-band abort. When it is set, any partly built word is discarded and bits 3:2 of register 0 are forced high. A guard counter ignores writes that follow an accepted write too closely, so a CPU instruction that writes twice on consecutive bus cycles feeds in only one bit.

Downstream bank-selection logic reads the four register values directly. It uses a per-register, one-cycle update pulse to learn when a value has just changed.

Top module: `serialRegPort`

## Requirements
- R1: A write with address bit 15 equal to 0 is ignored.
- R2: If a write is accepted at clock edge t, any write at edges t+1 and t+2 is ignored. A write at edge t+3 is accepted if it meets the other rules.
- R3: An accepted write with data bit 7 = 1 clears the shift buffer and bit count, sets bits 3:2 of register 0, leaves register 0's other bits unchanged, and pulses the update bit of register 0.
- R4: An accepted write with data bit 7 = 0 stores data bit 0 as the next payload bit, starting at bit 0 (LSB first).
- R5: The fifth payload bit completes the word. The word goes into the register numbered by address bits 14:13 of that write. It is visible after the same clock edge, and the next payload bit starts a new word.
- R6: After reset, register 0 reads 0x0C, registers 1 to 3 read 0, the update pulses are low, and the first accepted write begins a new word.
- R7: A write that carries the abort bit also starts the guard window of R2.
- R8: Only the fifth write's address selects the target register. The addresses of the first four payload writes have no effect.
- R9: Each register update raises that register's bit of `updPulse` for exactly one cycle, in the cycle its new value first appears. At most one bit is high at a time.
- R10: An ignored write changes no register, no buffered bit and no bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the current cycle |
| addr | input | 16 | CPU write address |
| data | input | 8 | CPU write data (bit 7 abort, bit 0 payload) |
| reg0Val | output | 5 | Register 0 value |
| reg1Val | output | 5 | Register 1 value |
| reg2Val | output | 5 | Register 2 value |
| reg3Val | output | 5 | Register 3 value |
| updPulse | output | 4 | One-cycle update pulse per register |

## Verification
The bench targets the guard window. It sends back-to-back writes and writes immediately after an abort. A design that counted those extra writes would commit a word early and store a shifted value.

It sends lower-half writes in the middle of a sequence. Payload writes with differing addresses before a fifth write then test the target choice: a design that latched the target too early would load the wrong register.

Aborts arriving partway through a word show whether stale buffered bits leak into the next word. A design that missed the forced bits, or cleared register 0's other bits, would be caught there.

A long random run, with a fixed seed and compared cycle by cycle against a bench model, covers pulse timing and mixed orderings.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int REG_BITS  = 5;
  localparam int REG_COUNT = 4;
  localparam int SEL_W     = $clog2(REG_COUNT);
  localparam int CNT_W     = $clog2(REG_BITS);
  localparam int ABORT_BIT = DATA_W - 1;
  localparam int SEL_LSB   = ADDR_W - 1 - SEL_W;
  localparam logic [REG_BITS-1:0] REG0_INIT = 5'h0C;
  localparam logic [REG_BITS-1:0] ABORT_SET = 5'h0C;

  typedef logic [REG_BITS-1:0] regWord_t;

  typedef struct packed {
    logic             shift;
    logic             commit;
    logic             abort;
    logic             bitVal;
    logic [CNT_W-1:0] bitPos;
    logic [SEL_W-1:0] sel;
  } srpStrobe_t;
endpackage

// File: rtl/srp_ctrl.sv
module srp_ctrl
  import srp_pkg::*;
#(
  parameter int GUARD_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output srpStrobe_t        strobe
);
  localparam int GW = $clog2(GUARD_CYCLES + 1);
  localparam logic [GW-1:0] GUARD_LOAD = GW'(GUARD_CYCLES - 1);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(REG_BITS - 1);

  logic [GW-1:0]    guardCnt;
  logic [CNT_W-1:0] bitCount;
  logic             accept;
  logic             isAbort;
  logic             lastBit;

  assign accept  = wrEn && addr[ADDR_W-1] && (guardCnt == '0);
  assign isAbort = data[ABORT_BIT];
  assign lastBit = (bitCount == LAST_POS);

  always_comb begin
    strobe.abort  = accept && isAbort;
    strobe.shift  = accept && !isAbort && !lastBit;
    strobe.commit = accept && !isAbort && lastBit;
    strobe.bitVal = data[0];
    strobe.bitPos = bitCount;
    strobe.sel    = addr[SEL_LSB +: SEL_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      guardCnt <= '0;
    end else if (accept) begin
      guardCnt <= GUARD_LOAD;
    end else if (guardCnt != '0) begin
      guardCnt <= guardCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
    end else if (accept) begin
      if (isAbort || lastBit) bitCount <= '0;
      else                    bitCount <= bitCount + 1'b1;
    end
  end

  // R2
  guard_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !accept ##1 !accept);

  // R7
  abort_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isAbort) |=> !accept);

  // R4
  bit_count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= LAST_POS);

  // R1
  low_addr_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr[ADDR_W-1]) |=> $stable(bitCount));
endmodule

// File: rtl/srp_datapath.sv
module srp_datapath
  import srp_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  srpStrobe_t                         strobe,
  output logic [REG_COUNT-1:0][REG_BITS-1:0] regFile,
  output logic [REG_COUNT-1:0]               updPulse
);
  regWord_t shiftBuf;
  regWord_t nextWord;

  always_comb begin
    nextWord = shiftBuf;
    nextWord[strobe.bitPos] = strobe.bitVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftBuf <= '0;
    end else if (strobe.abort || strobe.commit) begin
      shiftBuf <= '0;
    end else if (strobe.shift) begin
      shiftBuf <= nextWord;
    end
  end

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    logic hit;
    assign hit = strobe.commit && (strobe.sel == SEL_W'(i));
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          regFile[i]  <= REG0_INIT;
          updPulse[i] <= 1'b0;
        end else begin
          updPulse[i] <= hit || strobe.abort;
          if (strobe.abort)  regFile[i] <= regFile[i] | ABORT_SET;
          else if (hit)      regFile[i] <= nextWord;
        end
      end
    end else begin : g_other
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          regFile[i]  <= '0;
          updPulse[i] <= 1'b0;
        end else begin
          updPulse[i] <= hit;
          if (hit) regFile[i] <= nextWord;
        end
      end
    end
  end

  // R5
  commit_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> regFile[$past(strobe.sel)] == $past(nextWord));

  // R3
  abort_reg0_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.abort |=> ((regFile[0] & ABORT_SET) == ABORT_SET) && updPulse[0]);

  // R9
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(updPulse));

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.commit || strobe.abort) |=> $stable(regFile) && (updPulse == '0));
endmodule

// File: rtl/serialRegPort.sv
module serialRegPort
  import srp_pkg::*;
#(
  parameter int GUARD_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [15:0] addr,
  input  logic [7:0]  data,
  output logic [4:0]  reg0Val,
  output logic [4:0]  reg1Val,
  output logic [4:0]  reg2Val,
  output logic [4:0]  reg3Val,
  output logic [3:0]  updPulse
);
  srpStrobe_t                         strobe;
  logic [REG_COUNT-1:0][REG_BITS-1:0] regFile;

  srp_ctrl #(.GUARD_CYCLES(GUARD_CYCLES)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .data   (data),
    .strobe (strobe)
  );

  srp_datapath i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regFile  (regFile),
    .updPulse (updPulse)
  );

  assign reg0Val = regFile[0];
  assign reg1Val = regFile[1];
  assign reg2Val = regFile[2];
  assign reg3Val = regFile[3];
endmodule

// File: tb/test_serialRegPort.sv
module test_serialRegPort;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic [4:0]  reg0Val, reg1Val, reg2Val, reg3Val;
  logic [3:0]  updPulse;

  int checks = 0;
  int fails  = 0;

  int         mReg [4];
  logic [4:0] mBuf;
  int         mCnt;
  int         mGuard;
  logic [3:0] mPulse;
  logic [3:0] lastPulse;

  serialRegPort i_serialRegPort (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .data(data),
    .reg0Val(reg0Val), .reg1Val(reg1Val), .reg2Val(reg2Val), .reg3Val(reg3Val),
    .updPulse(updPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int getReg(int i);
    case (i)
      0: return int'(reg0Val);
      1: return int'(reg1Val);
      2: return int'(reg2Val);
      default: return int'(reg3Val);
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mReg[0] = 'h0C; mReg[1] = 0; mReg[2] = 0; mReg[3] = 0;
    mBuf = '0; mCnt = 0; mGuard = 0; mPulse = '0;
  endtask

  task automatic modelStep(logic we, logic [15:0] a, logic [7:0] d);
    int sel;
    mPulse = '0;
    if (we && a[15] && mGuard == 0) begin
      mGuard = 2;
      if (d[7]) begin
        mBuf = '0; mCnt = 0;
        mReg[0] = mReg[0] | 'h0C;
        mPulse = 4'b0001;
      end else begin
        mBuf[mCnt] = d[0];
        if (mCnt == 4) begin
          sel = int'(a[14:13]);
          mReg[sel] = int'(mBuf);
          mPulse[sel] = 1'b1;
          mBuf = '0; mCnt = 0;
        end else begin
          mCnt++;
        end
      end
    end else if (mGuard > 0) begin
      mGuard--;
    end
  endtask

  task automatic doCycle(logic we, logic [15:0] a, logic [7:0] d);
    wrEn = we; addr = a; data = d;
    @(posedge clk);
    modelStep(we, a, d);
    @(negedge clk);
    for (int i = 0; i < 4; i++) chk("R5 register value", getReg(i), mReg[i]);
    chk("R9 update pulse", int'(updPulse), int'(mPulse));
    lastPulse = updPulse;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) doCycle(1'b0, 16'h0000, 8'h00);
  endtask

  // five payload writes spaced by the guard; fifth at lastAddr
  task automatic serialLoad(logic [15:0] firstAddr, logic [15:0] lastAddr, logic [4:0] val);
    logic [3:0] pulseOnFifth;
    pulseOnFifth = '0;
    for (int i = 0; i < 5; i++) begin
      doCycle(1'b1, (i == 4) ? lastAddr : firstAddr, {7'b0, val[i]});
      if (i == 4) pulseOnFifth = updPulse;
      idle(2);
    end
    lastPulse = pulseOnFifth;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    modelReset();
    repeat (3) @(negedge clk);
    // R6 reset values
    chk("R6 reg0 reset", int'(reg0Val), 'h0C);
    chk("R6 reg1 reset", int'(reg1Val), 0);
    chk("R6 reg2 reset", int'(reg2Val), 0);
    chk("R6 reg3 reset", int'(reg3Val), 0);
    chk("R6 pulses reset", int'(updPulse), 0);
    rstN = 1'b1;
    idle(2);

    // R4 R5 R9: LSB-first load into register 1
    serialLoad(16'hA000, 16'hA000, 5'b10110);
    chk("R4 R5 reg1 value", int'(reg1Val), 'h16);
    chk("R9 pulse on reg1", int'(lastPulse), 'b0010);
    chk("R9 pulse dropped", int'(updPulse), 0);

    // R8: early addresses point at reg0, fifth at reg3
    serialLoad(16'h8000, 16'hE000, 5'b01011);
    chk("R8 reg3 from fifth addr", int'(reg3Val), 'h0B);
    chk("R8 reg0 untouched", int'(reg0Val), 'h0C);

    // R2 R10: writes at t+1, t+2 ignored
    doCycle(1'b1, 16'hC000, 8'h01);
    doCycle(1'b1, 16'hC000, 8'h01);
    doCycle(1'b1, 16'hC000, 8'h01);
    doCycle(1'b1, 16'hC000, 8'h00);
    idle(2);
    for (int i = 0; i < 3; i++) begin
      doCycle(1'b1, 16'hC000, 8'h00);
      idle(2);
    end
    chk("R2 reg2 after close writes", int'(reg2Val), 'h01);
    chk("R10 no partial bit from ignored write", int'(reg1Val), 'h16);

    // R1: lower-half writes in the middle of a word
    doCycle(1'b1, 16'hC000, 8'h01);
    idle(2);
    for (int i = 0; i < 4; i++) begin
      doCycle(1'b1, 16'h6000, 8'h00);
      idle(2);
    end
    for (int i = 0; i < 4; i++) begin
      doCycle(1'b1, 16'hC000, 8'h01);
      idle(2);
    end
    chk("R1 reg2 ignores low writes", int'(reg2Val), 'h1F);

    // R3: clear reg0, then abort mid-word
    serialLoad(16'h8000, 16'h8000, 5'b10001);
    chk("R3 reg0 preload", int'(reg0Val), 'h11);
    doCycle(1'b1, 16'hA000, 8'h01);
    idle(2);
    doCycle(1'b1, 16'hA000, 8'h01);
    idle(2);
    doCycle(1'b1, 16'hFFFF, 8'h80);
    chk("R3 reg0 bits set", int'(reg0Val), 'h1D);
    chk("R3 abort pulses reg0", int'(updPulse), 'b0001);
    // R7: writes right after the abort are ignored
    doCycle(1'b1, 16'hA000, 8'h01);
    doCycle(1'b1, 16'hA000, 8'h01);
    serialLoad(16'hA000, 16'hA000, 5'b00100);
    chk("R7 R3 reg1 clean word", int'(reg1Val), 'h04);

    // random phase
    for (int n = 0; n < 6000; n++) begin
      logic [15:0] a;
      logic [7:0]  d;
      logic        we;
      we = ($urandom_range(0, 3) != 0);
      a  = 16'($urandom());
      if ($urandom_range(0, 3) != 0) a[15] = 1'b1;
      d  = 8'($urandom());
      d[7] = ($urandom_range(0, 19) == 0);
      doCycle(we, a, d);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule